// File: doc/BRIEF.md
# Cache Tag Store with Zero-Wait Ready Generation

This block holds the tag and two status bits for each set of a direct-mapped cache and compares a stored tag against the upper address bits of the current bus cycle. From that comparison it produces a hit flag and an active-low bus-ready, so a cache hit can be answered with no wait states. The ready is produced here rather than in a separate controller, which keeps the controller out of the critical path between the address and the ready.

The ready is qualified by the entry's valid bit, its write-through bit and the direction of the processor access. A processor write to a write-through line never produces ready from this block, so the memory controller can answer after main memory accepts the write. The controller can still hold ready inactive at any time. It can also disable this block's ready drive entirely and take over the shared ready line. The shared ready line is modelled as a value plus a drive-enable. The status bits can be used in a dedicated way (valid and write-through) or as two generic bits with no meaning to the block.

An address is sampled on a clock edge and its result appears in the following cycle. The hold and drive-enable inputs act combinationally in that result cycle, so the controller can decide them in parallel with the lookup.

Top module: `tag_ready_store`

## Requirements
- R1: Reset clears every valid bit and every write-through bit but keeps the stored tags, so after reset a dedicated-mode lookup never hits, while a generic-mode lookup still compares the kept tags.
- R2: With `mode_generic` low at the address cycle, `hit` in the next cycle is 1 only if the stored tag at the registered index equals the registered tag and that entry's valid bit is 1.
- R3: With `mode_generic` high at the address cycle, `hit` in the next cycle is the raw tag equality, whatever the status bits hold.
- R4: When `match_mode` is low at the address cycle, `hit` is 0 in the next cycle.
- R5: When `cs` is low at the address cycle, `hit_en`, `rdy_en` and `hit` are all 0 in the next cycle; when `cs` is high, `hit_en` is 1.
- R6: `stat_out` shows the status of the registered index in every cycle: bit 1 is valid and bit 0 is write-through. This holds whatever the state of `cs`, `rdy_oe` and `rdy_hold`.
- R7: When it is driven, `rdy_val` is 0 in the result cycle exactly when `hit` is 1, no write-through block applies and `rdy_hold` is low; otherwise it is 1.
- R8: In dedicated mode, a write access whose entry has write-through set keeps `rdy_val` at 1 even on a hit; in generic mode no such block applies.
- R9: `rdy_hold` high in the result cycle forces `rdy_val` to 1.
- R10: `rdy_en` equals `hit_en` AND the current `rdy_oe`.
- R11: Parameter `WRITE_HIGH` = 1 treats `rw` = 1 as a write; `WRITE_HIGH` = 0 treats `rw` = 0 as a write; nothing else differs.
- R12: With `cs` high, `tag_we` stores `tag_in` and both bits of `stat_in` (bit 1 valid, bit 0 write-through) at `idx` on the clock edge. `stat_we` stores only the status bits. `tag_we` takes priority. A lookup sampled at that same edge sees the new contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs | input | 1 | Chip select for lookup and writes |
| idx | input | IDX_W | Set index |
| tag_in | input | TAG_W | Incoming tag |
| tag_we | input | 1 | Write tag and status |
| stat_we | input | 1 | Write status only |
| stat_in | input | 2 | Status to write: [1] valid, [0] write-through |
| match_mode | input | 1 | Compare enable for this access |
| mode_generic | input | 1 | 1: generic status, 0: dedicated status |
| rw | input | 1 | Access direction, polarity set by WRITE_HIGH |
| rdy_hold | input | 1 | Forces ready inactive (high) |
| rdy_oe | input | 1 | Lets the block drive the ready line |
| hit | output | 1 | Qualified hit |
| hit_en | output | 1 | Drive-enable for hit |
| stat_out | output | 2 | Status of the registered index |
| rdy_val | output | 1 | Active-low ready value |
| rdy_en | output | 1 | Drive-enable for ready |

## Verification
A status or tag write and a lookup of the same index can fall into the same cycle. The bench provokes this by issuing writes and lookups at random on a narrow range of indices, so collisions are frequent. Each such result is judged against a model in which the write lands before the lookup is evaluated. The other collision pits a write-through block against a hit while the hold and drive-enable inputs toggle independently; the bench judges the ready value cycle by cycle against a priority of hold, then block, then hit.

// File: rtl/tag_rdy_pkg.sv
package tag_rdy_pkg;

    // Two status bits per entry; in generic mode they carry no meaning.
    typedef struct packed {
        logic vld;
        logic wt;
    } stat_t;

endpackage

// File: rtl/tag_array.sv
module tag_array
    import tag_rdy_pkg::*;
#(
    parameter int SETS  = 64,
    parameter int TAG_W = 12,
    localparam int IDX_W = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_tag,
    input  logic             wr_stat,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_t,
    input  stat_t            wr_s,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [TAG_W-1:0] rd_tag,
    output stat_t            rd_stat
);

    logic [TAG_W-1:0] tag_d [SETS];
    logic [TAG_W-1:0] tag_q [SETS];
    stat_t            stat_d [SETS];
    stat_t            stat_q [SETS];

    // Next-value computation for the whole array.
    always_comb begin
        for (int e = 0; e < SETS; e++) begin
            tag_d[e]  = tag_q[e];
            stat_d[e] = stat_q[e];
        end
        if (wr_tag) begin
            tag_d[wr_idx]  = wr_t;
            stat_d[wr_idx] = wr_s;
        end else if (wr_stat) begin
            stat_d[wr_idx] = wr_s;
        end
    end

    // Tags keep their contents through reset; only status is cleared.
    always_ff @(posedge clk) begin
        for (int e = 0; e < SETS; e++) begin
            tag_q[e] <= tag_d[e];
        end
    end

    generate
        for (genvar e = 0; e < SETS; e++) begin : g_stat
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    stat_q[e] <= '0;
                end else begin
                    stat_q[e] <= stat_d[e];
                end
            end
        end
    endgenerate

    assign rd_tag  = tag_q[rd_idx];
    assign rd_stat = stat_q[rd_idx];

    // R12: a tag write lands at the addressed entry
    p_tag_store_r12: assert property (@(posedge clk) disable iff (!rst_n)
        wr_tag |=> (tag_q[$past(wr_idx)] == $past(wr_t)) && (stat_q[$past(wr_idx)] == $past(wr_s)));

    // R12: a status-only write leaves the tag untouched
    p_stat_only_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat && !wr_tag) |=> (tag_q[$past(wr_idx)] == $past(tag_q[wr_idx]))
                                 && (stat_q[$past(wr_idx)] == $past(wr_s)));

endmodule

// File: rtl/tag_match.sv
module tag_match
    import tag_rdy_pkg::*;
#(
    parameter int TAG_W = 12
) (
    input  logic             lk_cs,
    input  logic             lk_cmp,
    input  logic             lk_gen,
    input  logic [TAG_W-1:0] lk_tag,
    input  logic [TAG_W-1:0] stored_tag,
    input  stat_t            stored_stat,
    output logic             hit,
    output logic             hit_en
);

    logic eq;

    always_comb begin
        eq     = (stored_tag == lk_tag);
        hit_en = lk_cs;
        hit    = 1'b0;
        if (lk_cs && lk_cmp) begin
            hit = lk_gen ? eq : (eq && stored_stat.vld);
        end
    end

endmodule

// File: rtl/rdy_gen.sv
module rdy_gen
    import tag_rdy_pkg::*;
(
    input  logic  hit,
    input  logic  hit_en,
    input  logic  lk_gen,
    input  logic  lk_wr,
    input  stat_t stored_stat,
    input  logic  rdy_hold,
    input  logic  rdy_oe,
    output logic  wt_block,
    output logic  rdy_val,
    output logic  rdy_en
);

    always_comb begin
        wt_block = !lk_gen && lk_wr && stored_stat.wt;
        rdy_val  = !(hit && !wt_block && !rdy_hold);
        rdy_en   = hit_en && rdy_oe;
    end

endmodule

// File: rtl/tag_ready_store.sv
module tag_ready_store
    import tag_rdy_pkg::*;
#(
    parameter int SETS       = 64,
    parameter int TAG_W      = 12,
    parameter bit WRITE_HIGH = 1'b1,
    localparam int IDX_W     = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs,
    input  logic [IDX_W-1:0] idx,
    input  logic [TAG_W-1:0] tag_in,
    input  logic             tag_we,
    input  logic             stat_we,
    input  logic [1:0]       stat_in,
    input  logic             match_mode,
    input  logic             mode_generic,
    input  logic             rw,
    input  logic             rdy_hold,
    input  logic             rdy_oe,
    output logic             hit,
    output logic             hit_en,
    output logic [1:0]       stat_out,
    output logic             rdy_val,
    output logic             rdy_en
);

    typedef struct packed {
        logic             cs;
        logic             cmp;
        logic             gen;
        logic             wr;
        logic [IDX_W-1:0] idx;
        logic [TAG_W-1:0] tag;
    } lk_t;

    lk_t              lk_d, lk_q;
    logic             is_wr;
    logic [TAG_W-1:0] rd_tag;
    stat_t            rd_stat;
    logic             wt_block;

    // Direction polarity picked at elaboration.
    generate
        if (WRITE_HIGH) begin : g_wr_hi
            assign is_wr = rw;
        end else begin : g_wr_lo
            assign is_wr = !rw;
        end
    endgenerate

    always_comb begin
        lk_d     = lk_q;
        lk_d.cs  = cs;
        lk_d.cmp = match_mode;
        lk_d.gen = mode_generic;
        lk_d.wr  = is_wr;
        lk_d.idx = idx;
        lk_d.tag = tag_in;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lk_q <= '0;
        end else begin
            lk_q <= lk_d;
        end
    end

    tag_array #(.SETS(SETS), .TAG_W(TAG_W)) u_arr (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_tag  (cs && tag_we),
        .wr_stat (cs && stat_we),
        .wr_idx  (idx),
        .wr_t    (tag_in),
        .wr_s    (stat_t'(stat_in)),
        .rd_idx  (lk_q.idx),
        .rd_tag  (rd_tag),
        .rd_stat (rd_stat)
    );

    tag_match #(.TAG_W(TAG_W)) u_match (
        .lk_cs       (lk_q.cs),
        .lk_cmp      (lk_q.cmp),
        .lk_gen      (lk_q.gen),
        .lk_tag      (lk_q.tag),
        .stored_tag  (rd_tag),
        .stored_stat (rd_stat),
        .hit         (hit),
        .hit_en      (hit_en)
    );

    rdy_gen u_rdy (
        .hit         (hit),
        .hit_en      (hit_en),
        .lk_gen      (lk_q.gen),
        .lk_wr       (lk_q.wr),
        .stored_stat (rd_stat),
        .rdy_hold    (rdy_hold),
        .rdy_oe      (rdy_oe),
        .wt_block    (wt_block),
        .rdy_val     (rdy_val),
        .rdy_en      (rdy_en)
    );

    assign stat_out = rd_stat;

    // R2: an invalid entry never hits in dedicated mode
    p_inv_nohit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!lk_q.gen && !rd_stat.vld) |-> !hit);

    // R3: generic mode reports raw equality
    p_generic_raw_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_en && lk_q.cmp && lk_q.gen) |-> (hit == (rd_tag == lk_q.tag)));

    // R4: compare disabled gives no hit
    p_nocmp_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_q.cmp |-> !hit);

    // R5: deselect removes both drives in the next cycle
    p_desel_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !cs |=> (!hit_en && !rdy_en && !hit));

    // R7: a clean hit asserts ready; no hit keeps it high
    p_hit_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !wt_block && !rdy_hold) |-> !rdy_val);
    p_miss_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> rdy_val);

    // R8: write to a write-through line in dedicated mode is blocked
    p_wt_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_q.wr && !lk_q.gen && rd_stat.wt) |-> rdy_val);

    // R9: hold forces ready high
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rdy_hold |-> rdy_val);

    // R10: drive-enable off means no drive
    p_oe_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !rdy_oe |-> !rdy_en);

endmodule

// File: tb/tag_ready_store_test.sv
module tag_ready_store_test;

    localparam int SETS  = 64;
    localparam int TAG_W = 12;
    localparam int IDX_W = $clog2(SETS);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cs = 1'b0;
    logic [IDX_W-1:0] idx = '0;
    logic [TAG_W-1:0] tag_in = '0;
    logic             tag_we = 1'b0, stat_we = 1'b0;
    logic [1:0]       stat_in = '0;
    logic             match_mode = 1'b0, mode_generic = 1'b0, rw = 1'b0;
    logic             rdy_hold = 1'b0, rdy_oe = 1'b0;
    logic             hit, hit_en, rdy_val, rdy_en;
    logic [1:0]       stat_out;
    logic             hit2, hit_en2, rdy_val2, rdy_en2;
    logic [1:0]       stat_out2;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    string tag_ovr = "";

    // behavioural model state
    int m_tag [SETS];
    bit m_vld [SETS];
    bit m_wt  [SETS];
    bit l_cs, l_cmp, l_gen, l_wr;
    int l_idx, l_tag;

    always #5 clk = !clk;

    tag_ready_store #(.SETS(SETS), .TAG_W(TAG_W), .WRITE_HIGH(1'b1)) uut (
        .clk(clk), .rst_n(rst_n), .cs(cs), .idx(idx), .tag_in(tag_in),
        .tag_we(tag_we), .stat_we(stat_we), .stat_in(stat_in),
        .match_mode(match_mode), .mode_generic(mode_generic), .rw(rw),
        .rdy_hold(rdy_hold), .rdy_oe(rdy_oe), .hit(hit), .hit_en(hit_en),
        .stat_out(stat_out), .rdy_val(rdy_val), .rdy_en(rdy_en)
    );

    // R11: low-polarity variant fed the inverted direction
    tag_ready_store #(.SETS(SETS), .TAG_W(TAG_W), .WRITE_HIGH(1'b0)) uut_wl (
        .clk(clk), .rst_n(rst_n), .cs(cs), .idx(idx), .tag_in(tag_in),
        .tag_we(tag_we), .stat_we(stat_we), .stat_in(stat_in),
        .match_mode(match_mode), .mode_generic(mode_generic), .rw(!rw),
        .rdy_hold(rdy_hold), .rdy_oe(rdy_oe), .hit(hit2), .hit_en(hit_en2),
        .stat_out(stat_out2), .rdy_val(rdy_val2), .rdy_en(rdy_en2)
    );

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", rq, act, exp, $time);
        end
    endtask

    task automatic compare();
        bit e_hit, e_blk, e_rv, e_re;
        string rq;
        e_hit = l_cs && l_cmp && (m_tag[l_idx] == l_tag) && (l_gen || m_vld[l_idx]);
        e_blk = !l_gen && l_wr && m_wt[l_idx];
        e_rv  = !(e_hit && !e_blk && !rdy_hold);
        e_re  = l_cs && rdy_oe;
        rq = !l_cs ? "R5" : (!l_cmp ? "R4" : (l_gen ? "R3" : "R2"));
        if (tag_ovr != "") rq = tag_ovr;
        chk(rq, {31'd0, hit}, {31'd0, e_hit});
        chk("R5", {31'd0, hit_en}, {31'd0, l_cs});
        chk(l_cs ? "R10" : "R5", {31'd0, rdy_en}, {31'd0, e_re});
        if (l_cs) begin
            rq = rdy_hold ? "R9" : (e_blk ? "R8" : "R7");
            chk(rq, {31'd0, rdy_val}, {31'd0, e_rv});
        end
        chk(tag_ovr != "" ? tag_ovr : "R6", {30'd0, stat_out}, {30'd0, m_vld[l_idx], m_wt[l_idx]});
        chk("R11", {27'd0, hit2, hit_en2, stat_out2, rdy_en2 ? rdy_val2 : 1'b0},
                   {27'd0, hit,  hit_en,  stat_out,  rdy_en  ? rdy_val  : 1'b0});
    endtask

    // Inputs are set at the negedge before calling; check, then advance.
    task automatic cyc(input bit do_cmp);
        #1;
        if (do_cmp) compare();
        @(posedge clk);
        if (!rst_n) begin
            for (int e = 0; e < SETS; e++) begin m_vld[e] = 0; m_wt[e] = 0; end
            l_cs = 0; l_cmp = 0; l_gen = 0; l_wr = 0; l_idx = 0; l_tag = 0;
        end else begin
            if (cs && tag_we) begin
                m_tag[idx] = int'(tag_in); m_vld[idx] = stat_in[1]; m_wt[idx] = stat_in[0];
            end else if (cs && stat_we) begin
                m_vld[idx] = stat_in[1]; m_wt[idx] = stat_in[0];
            end
            l_cs = cs; l_cmp = match_mode; l_gen = mode_generic; l_wr = rw;
            l_idx = int'(idx); l_tag = int'(tag_in);
        end
        @(negedge clk);
    endtask

    task automatic quiet();
        cs = 1; tag_we = 0; stat_we = 0; match_mode = 0; rdy_hold = 0; rdy_oe = 1; rw = 0;
    endtask

    initial begin
        for (int e = 0; e < SETS; e++) begin m_tag[e] = -1; m_vld[e] = 0; m_wt[e] = 0; end
        @(negedge clk);
        rst_n = 0;
        cyc(0); cyc(0); cyc(0);
        rst_n = 1;
        // R5: reset state of the drives
        #1;
        chk("R5", {30'd0, hit_en, rdy_en}, 32'd0);
        // R12: fill every entry with tag = index, valid set
        quiet();
        for (int e = 0; e < SETS; e++) begin
            idx = IDX_W'(e); tag_in = TAG_W'(e); tag_we = 1; stat_in = 2'b10;
            cyc(1);
        end
        tag_we = 0;
        // R12: read back with a dedicated compare
        tag_ovr = "R12";
        for (int e = 0; e < SETS; e += 7) begin
            idx = IDX_W'(e); tag_in = TAG_W'(e); match_mode = 1; mode_generic = 0;
            cyc(0); cyc(1);
        end
        tag_ovr = "";
        // R1: reset again; valid bits cleared, tags kept
        rst_n = 0; cyc(0); cyc(0);
        rst_n = 1;
        quiet();
        tag_ovr = "R1";
        for (int e = 0; e < 8; e++) begin
            idx = IDX_W'(e); tag_in = TAG_W'(e); match_mode = 1; mode_generic = 0;
            cyc(0); cyc(1);
            mode_generic = 1;
            cyc(0); cyc(1);
        end
        tag_ovr = "";
        // R8/R9/R10 directed: entry 3 write-through valid, tag 3
        idx = 3; tag_in = 3; tag_we = 1; stat_in = 2'b11; match_mode = 0; cyc(1);
        tag_we = 0; match_mode = 1; mode_generic = 0; rw = 1; cyc(1);
        rw = 0; cyc(1);
        rdy_hold = 1; cyc(1);
        rdy_hold = 0; rdy_oe = 0; cyc(1);
        rdy_oe = 1; mode_generic = 1; rw = 1; cyc(1);
        cyc(1);
        // random mix on a narrow index/tag range to force collisions
        for (int n = 0; n < 6000; n++) begin
            cs           = ($urandom_range(0, 9) != 0);
            idx          = IDX_W'($urandom_range(0, 7));
            tag_in       = TAG_W'($urandom_range(0, 3));
            tag_we       = ($urandom_range(0, 5) == 0);
            stat_we      = ($urandom_range(0, 5) == 0);
            stat_in      = 2'($urandom_range(0, 3));
            match_mode   = ($urandom_range(0, 7) != 0);
            mode_generic = ($urandom_range(0, 3) == 0);
            rw           = 1'($urandom_range(0, 1));
            rdy_hold     = ($urandom_range(0, 5) == 0);
            rdy_oe       = ($urandom_range(0, 5) != 0);
            cyc(1);
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule